// File: doc/BRIEF.md
# Nine-Bit Majority-Vote Serial Receiver

This block receives asynchronous serial frames of eleven bit times: a low start bit, eight data bits sent least significant bit first, a ninth bit, and a stop bit. A free-running strobe at sixteen times the bit rate paces it. The serial line first passes through a synchronizer. A high-to-low step seen on a strobe restarts a sixteen-slice counter, so each bit time lines up with that counter. Each bit takes the two-of-three majority of the line as seen in three adjacent middle slices.

A frame whose start bit votes high is dropped at once, and the receiver goes back to hunting for a falling step. A good frame shifts its nine bits in. At the voting point of the stop bit, the byte and the ninth bit are handed to the output holding registers and the full flag is raised. This happens only when the flag is currently low and either the address filter is off or the ninth bit is one. Otherwise the frame is discarded. The host clears the full flag with a one-cycle strobe.

Top module: `ninebit_vote_rx`

## Requirements
- R1: While reset is asserted and right after it, rxFull, rxByte and rxNinth are all zero.
- R2: While rcvEnable is low, falling steps on serialIn start no frame, and rxFull, rxByte and rxNinth keep their values.
- R3: Each bit value is the majority of three line samples. They are taken at slice counts 8, 9 and 10, counted in sliceTick strobes after the tick on which the start step was seen. A single disturbed slice between them does not change the bit.
- R4: If the start bit votes 1, the frame is abandoned with no change to the outputs, and the next falling step starts a new frame that is received normally.
- R5: After a valid start bit, the next eight voted bits form rxByte with the first one at bit 0, and the ninth voted bit appears on rxNinth.
- R6: A frame is loaded only if rxFull is 0 and either addrOnly is 0 or the ninth bit is 1. A frame that fails this leaves rxFull, rxByte and rxNinth unchanged.
- R7: A one-cycle flagClr pulse drives rxFull to 0 on the next cycle. If a load and flagClr fall in the same cycle, the load wins and rxFull becomes 1.
- R8: The stop bit value is not checked. A frame whose stop bit is 0 is still loaded. After the stop-bit voting point the receiver waits for a new falling step, which needs the line to go high first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| sliceTick | input | 1 | One-cycle strobe at sixteen times the bit rate |
| rcvEnable | input | 1 | Reception enable |
| addrOnly | input | 1 | Address filter: load only frames whose ninth bit is 1 |
| flagClr | input | 1 | Host strobe that clears rxFull |
| rxByte | output | 8 | Received data byte |
| rxNinth | output | 1 | Received ninth bit |
| rxFull | output | 1 | Frame-loaded flag |

## Verification
The bench builds the block with its default parameters: eight data bits, sixteen slices per bit and a two-stage synchronizer. It feeds sliceTick once every four clocks, so every frame fits in about seven hundred cycles. With this spacing the bench can force a single slice of the line to the wrong value, and that slice lands on the middle vote sample of any of the eleven bit positions. Start-step alignment, voting and the load rule can therefore all be exercised, including the case where load and clear coincide.

// File: rtl/nbrx_pkg.sv
package nbrx_pkg;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_FRAME = 1'b1
  } rxState_t;

  typedef struct packed {
    logic active;    // frame in progress, slice counter runs
    logic clearCnt;  // start step seen, restart slice counter
    logic shiftIn;   // take current voted bit into the shifter
    logic commit;    // stop-bit vote point, attempt load
  } rxStrb_t;

endpackage

// File: rtl/nbrx_datapath.sv
module nbrx_datapath
  import nbrx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 serialIn,
  input  logic                 sliceTick,
  input  logic                 addrOnly,
  input  logic                 flagClr,
  input  rxStrb_t              strb,
  output logic                 fallSeen,
  output logic                 voteDone,
  output logic                 votedBit,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxNinth,
  output logic                 rxFull
);

  localparam int CNT_W = $clog2(OVS);
  localparam int SH_W  = DATA_BITS + 1;
  localparam logic [CNT_W-1:0] VOTE_A = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] VOTE_B = CNT_W'(OVS / 2 + 1);
  localparam logic [CNT_W-1:0] VOTE_C = CNT_W'(OVS / 2 + 2);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lineNow;
  logic                   prevLine;
  logic [CNT_W-1:0]       sliceCnt;
  logic                   sampA;
  logic                   sampB;
  logic [SH_W-1:0]        shReg;
  logic                   loadOk;

  // Synchronizer, idle level high
  always_ff @(posedge clk) begin
    if (rst) syncChain <= '1;
    else     syncChain <= {syncChain[SYNC_STAGES-2:0], serialIn};
  end
  assign lineNow = syncChain[SYNC_STAGES-1];

  // Edge detection in the slice domain
  always_ff @(posedge clk) begin
    if (rst)            prevLine <= 1'b1;
    else if (sliceTick) prevLine <= lineNow;
  end
  assign fallSeen = sliceTick & prevLine & ~lineNow;

  // Bit-slice counter, realigned on the start step
  always_ff @(posedge clk) begin
    if (rst || strb.clearCnt)         sliceCnt <= '0;
    else if (sliceTick && strb.active) sliceCnt <= sliceCnt + 1'b1;
  end

  // Two stored samples plus the live third
  always_ff @(posedge clk) begin
    if (rst) begin
      sampA <= 1'b1;
      sampB <= 1'b1;
    end else if (sliceTick && strb.active) begin
      if (sliceCnt == VOTE_A) sampA <= lineNow;
      if (sliceCnt == VOTE_B) sampB <= lineNow;
    end
  end
  assign voteDone = sliceTick & strb.active & (sliceCnt == VOTE_C);
  assign votedBit = (sampA & sampB) | (sampA & lineNow) | (sampB & lineNow);

  // Shifter: first received bit ends at position 0
  always_ff @(posedge clk) begin
    if (rst)              shReg <= '0;
    else if (strb.shiftIn) shReg <= {votedBit, shReg[SH_W-1:1]};
  end

  // Gated hand-off to the holding registers
  assign loadOk = strb.commit & ~rxFull & (~addrOnly | shReg[SH_W-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rxByte  <= '0;
      rxNinth <= 1'b0;
    end else if (loadOk) begin
      rxByte  <= shReg[DATA_BITS-1:0];
      rxNinth <= shReg[SH_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rxFull <= 1'b0;
    else if (loadOk)  rxFull <= 1'b1;
    else if (flagClr) rxFull <= 1'b0;
  end

endmodule

// File: rtl/nbrx_control.sv
module nbrx_control
  import nbrx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    rcvEnable,
  input  logic    fallSeen,
  input  logic    voteDone,
  input  logic    votedBit,
  output rxStrb_t strb
);

  localparam int FRAME_BITS = DATA_BITS + 3;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(FRAME_BITS - 1);

  rxState_t         state;
  rxState_t         nextState;
  logic [IDX_W-1:0] bitIdx;

  always_comb begin
    strb        = '0;
    nextState   = state;
    strb.active = (state == ST_FRAME);
    case (state)
      ST_HUNT: begin
        if (rcvEnable && fallSeen) begin
          strb.clearCnt = 1'b1;
          nextState     = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (!rcvEnable) begin
          nextState = ST_HUNT;
        end else if (voteDone) begin
          if (bitIdx == '0) begin
            if (votedBit) nextState = ST_HUNT;  // false start
          end else if (bitIdx == STOP_IDX) begin
            strb.commit = 1'b1;
            nextState   = ST_HUNT;
          end else begin
            strb.shiftIn = 1'b1;
          end
        end
      end
      default: nextState = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_HUNT;
      bitIdx <= '0;
    end else begin
      state <= nextState;
      if (strb.clearCnt)                    bitIdx <= '0;
      else if (state == ST_FRAME && voteDone) bitIdx <= bitIdx + 1'b1;
    end
  end

endmodule

// File: rtl/ninebit_vote_rx.sv
module ninebit_vote_rx
  import nbrx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 serialIn,
  input  logic                 sliceTick,
  input  logic                 rcvEnable,
  input  logic                 addrOnly,
  input  logic                 flagClr,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxNinth,
  output logic                 rxFull
);

  rxStrb_t ctlStrb;
  logic    fallSeen;
  logic    voteDone;
  logic    votedBit;
  logic    rcvBusy;

  assign rcvBusy = ctlStrb.active;

  nbrx_control #(.DATA_BITS(DATA_BITS)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .rcvEnable(rcvEnable),
    .fallSeen (fallSeen),
    .voteDone (voteDone),
    .votedBit (votedBit),
    .strb     (ctlStrb)
  );

  nbrx_datapath #(
    .DATA_BITS  (DATA_BITS),
    .OVS        (OVS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .serialIn (serialIn),
    .sliceTick(sliceTick),
    .addrOnly (addrOnly),
    .flagClr  (flagClr),
    .strb     (ctlStrb),
    .fallSeen (fallSeen),
    .voteDone (voteDone),
    .votedBit (votedBit),
    .rxByte   (rxByte),
    .rxNinth  (rxNinth),
    .rxFull   (rxFull)
  );

endmodule

// File: rtl/ninebit_vote_rx_chk.sv
module ninebit_vote_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rcvEnable,
  input logic                 addrOnly,
  input logic                 flagClr,
  input logic                 rcvBusy,
  input logic [DATA_BITS-1:0] rxByte,
  input logic                 rxNinth,
  input logic                 rxFull
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rxFull && !rxNinth && rxByte == '0));

  // R2
  disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rcvEnable |=> !rcvBusy);

  // R6
  filter_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rxFull) |-> (!$past(addrOnly) || rxNinth));

  // R6
  held_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (rxFull && !flagClr) |=> (rxFull && $stable(rxByte) && $stable(rxNinth)));

  // R7
  host_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rxFull && flagClr) |=> !rxFull);

endmodule

bind ninebit_vote_rx ninebit_vote_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rcvEnable(rcvEnable),
  .addrOnly (addrOnly),
  .flagClr  (flagClr),
  .rcvBusy  (rcvBusy),
  .rxByte   (rxByte),
  .rxNinth  (rxNinth),
  .rxFull   (rxFull)
);

// File: tb/ninebit_vote_rx_bench.sv
module ninebit_vote_rx_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serialIn = 1'b1;
  logic       sliceTick;
  logic       rcvEnable = 1'b1;
  logic       addrOnly = 1'b0;
  logic       flagClr = 1'b0;
  logic [7:0] rxByte;
  logic       rxNinth;
  logic       rxFull;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [1:0] tickCnt = '0;
  bit watchFull = 0;
  bit sawFull = 0;

  always #2 clk = ~clk;

  always @(negedge clk) tickCnt <= tickCnt + 2'd1;
  assign sliceTick = (tickCnt == 2'd0);

  always @(negedge clk) if (watchFull && rxFull) sawFull = 1;

  ninebit_vote_rx u_ninebit_vote_rx (
    .clk(clk), .rst(rst), .serialIn(serialIn), .sliceTick(sliceTick),
    .rcvEnable(rcvEnable), .addrOnly(addrOnly), .flagClr(flagClr),
    .rxByte(rxByte), .rxNinth(rxNinth), .rxFull(rxFull)
  );

  // entry: {addrOnly, ninth, data[7:0], clrBefore, expLoad}
  localparam int NVEC = 8;
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'hA5, 1'b1, 1'b1},
    {1'b0, 1'b1, 8'h3C, 1'b1, 1'b1},
    {1'b1, 1'b0, 8'hF0, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'h81, 1'b1, 1'b1},
    {1'b0, 1'b0, 8'h55, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b0, 8'hFF, 1'b1, 1'b1},
    {1'b1, 1'b0, 8'h12, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitTick();
    @(posedge clk);
    while (!sliceTick) @(posedge clk);
  endtask

  task automatic holdLine(input logic v, input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      serialIn = v;
      waitTick();
    end
  endtask

  // one bit time; glitch flips the line for slice 11 only
  task automatic sendBit(input logic v, input logic glitch);
    for (int j = 1; j <= 16; j++) begin
      @(negedge clk);
      serialIn = (glitch && j == 11) ? ~v : v;
      waitTick();
    end
  endtask

  task automatic sendFrame(input logic [8:0] d9, input logic stopV, input logic [10:0] gmask);
    sendBit(1'b0, gmask[0]);
    for (int i = 0; i < 9; i++) sendBit(d9[i], gmask[i+1]);
    sendBit(stopV, gmask[10]);
    holdLine(1'b1, 6);
  endtask

  task automatic pulseClr();
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  initial begin
    logic [7:0] expByte;
    logic       expNinth;
    logic       expFull;

    // R1 reset state
    repeat (5) @(negedge clk);
    check("R1 full in reset", rxFull, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 byte", rxByte, 0);
    check("R1 ninth", rxNinth, 0);
    check("R1 full", rxFull, 0);
    holdLine(1'b1, 4);

    // R2 disabled receiver ignores a frame
    rcvEnable = 1'b0;
    sendFrame({1'b1, 8'h5A}, 1'b1, '0);
    check("R2 full stays low", rxFull, 0);
    check("R2 byte untouched", rxByte, 0);
    rcvEnable = 1'b1;
    holdLine(1'b1, 4);

    // R4 false start then a valid frame
    holdLine(1'b0, 5);
    holdLine(1'b1, 24);
    check("R4 false start no load", rxFull, 0);
    check("R4 false start byte", rxByte, 0);
    sendFrame({1'b0, 8'h96}, 1'b1, '0);
    check("R4 resume full", rxFull, 1);
    check("R4 resume byte", rxByte, 8'h96);
    expByte = 8'h96; expNinth = 1'b0; expFull = 1'b1;

    // Vector walk: R5 order, R6 gating, R3 single-slice glitch
    for (int i = 0; i < NVEC; i++) begin
      logic [10:0] gm;
      gm = 11'b1 << ((i * 3 + 1) % 11);
      addrOnly = VEC[i][11];
      if (VEC[i][1]) begin
        pulseClr();
        expFull = 1'b0;
      end
      sendFrame({VEC[i][10], VEC[i][9:2]}, 1'b1, gm);
      if (VEC[i][0]) begin
        expByte = VEC[i][9:2]; expNinth = VEC[i][10]; expFull = 1'b1;
      end
      check("R6 full flag", rxFull, expFull);
      check("R5 R3 byte", rxByte, expByte);
      check("R5 ninth bit", rxNinth, expNinth);
    end
    addrOnly = 1'b0;

    // R3 every bit disturbed in one slice
    pulseClr();
    sendFrame({1'b1, 8'hC3}, 1'b1, '1);
    check("R3 all glitched byte", rxByte, 8'hC3);
    check("R3 all glitched ninth", rxNinth, 1);

    // R7 clear strobe
    pulseClr();
    @(negedge clk);
    check("R7 clear", rxFull, 0);

    // R7 load and clear together: load wins
    sawFull = 0;
    watchFull = 1;
    @(negedge clk);
    flagClr = 1'b1;
    sendFrame({1'b0, 8'h6E}, 1'b1, '0);
    flagClr = 1'b0;
    watchFull = 0;
    @(negedge clk);
    check("R7 load beats clear", sawFull, 1);
    check("R7 load beats clear byte", rxByte, 8'h6E);
    check("R7 cleared after", rxFull, 0);

    // R8 stop bit low still loads, then rehunt after line high
    sendBit(1'b0, 1'b0);
    for (int i = 0; i < 9; i++) sendBit(i == 8 ? 1'b0 : ((8'h4B >> i) & 1), 1'b0);
    sendBit(1'b0, 1'b0);
    holdLine(1'b0, 20);
    check("R8 low stop loads", rxFull, 1);
    check("R8 low stop byte", rxByte, 8'h4B);
    holdLine(1'b1, 20);
    pulseClr();
    sendFrame({1'b1, 8'hE7}, 1'b1, '0);
    check("R8 next frame full", rxFull, 1);
    check("R8 next frame byte", rxByte, 8'hE7);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule